// File: doc/BRIEF.md
# Dual-Channel Zero-Sample Detector

This block watches a stereo stream of audio sample words and reports, for each channel, when a long unbroken run of all-zero samples has arrived. A sample counts only on a cycle where the sample-valid strobe is high. Each channel keeps a run counter. The counter advances on every zero sample and clears on any nonzero one. Once the counter reaches the run length (1024 by default), that channel is declared silent.

A channel takes part in detection only while it is enabled as an input to the output mixer. A disabled channel never reports silence, and its counter is held at zero. A 2-bit select code routes the two per-channel results onto two flag outputs. One select value swaps the channels onto the opposite pins. A mute-enable control turns each channel's silence result into a mute request for the gain stage that follows. External circuits can use the flags to drive their own muting.

Top module: `zero_run_flagger`

## Requirements
- R1: A channel's silence result goes high after exactly RUN_LEN consecutive valid zero samples on an enabled channel; after RUN_LEN-1 it is still low. Both results are visible on the outputs in the cycle after the strobe's clock edge.
- R2: A valid sample with any bit set (including only the top bit) clears that channel's run and drops its silence result after that same clock edge.
- R3: The run counter saturates: while valid zero samples continue past RUN_LEN, the silence result stays high.
- R4: Sample words presented while the valid strobe is low are ignored: they neither advance nor clear a run.
- R5: While a channel's enable is low its silence result is low and its run restarts from zero, so after re-enabling it needs a full RUN_LEN zeros again.
- R6: Select code 2'b00 holds both flag outputs low.
- R7: Select codes 2'b01 and 2'b11 drive both flags with (left silent AND right silent).
- R8: Select code 2'b10 drives the left flag with the right channel's silence result and the right flag with the left channel's.
- R9: Each mute request equals mute_en AND that channel's silence result. Mute requests are always low while mute_en is low.
- R10: After reset both flags and both mute requests are low and both runs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe; both words are taken when high |
| smp_left | input | SAMPLE_W | Left sample word |
| smp_right | input | SAMPLE_W | Right sample word |
| flag_sel | input | 2 | Flag routing code (00 off, 01/11 both-silent, 10 crossed) |
| chan_en | input | 2 | Mixer input enables, bit 0 left, bit 1 right |
| mute_en | input | 1 | Enables the mute requests |
| zflag_l | output | 1 | Left flag pin, 1 = silence detected |
| zflag_r | output | 1 | Right flag pin, 1 = silence detected |
| mute_req_l | output | 1 | Mute request for the left gain stage |
| mute_req_r | output | 1 | Mute request for the right gain stage |

## Verification
The hardest states to reach are those where the two channels stand at different run positions right at the threshold. Examples are one channel saturated while the other has just been cleared, and a run sitting at RUN_LEN-1 when strobe-low cycles with nonzero words arrive. The stimulus gets there by holding the channels together for a full run, then breaking one side with a word that has only the top bit set. It then re-grows that side while the other stays saturated, and finally parks a re-enabled channel one sample short of the threshold before feeding idle garbage. A bench model with its own counters predicts every cycle, so the crossed routing and mute gating are compared in all of these states.

// File: rtl/zrf_pkg.sv
package zrf_pkg;

  typedef enum logic [1:0] {
    FSEL_OFF    = 2'b00,
    FSEL_BOTH_A = 2'b01,
    FSEL_CROSS  = 2'b10,
    FSEL_BOTH_B = 2'b11
  } fsel_e;

  // Returns {left_pin, right_pin} for a routing code and two silence results.
  function automatic logic [1:0] route_flags(input logic [1:0] sel,
                                             input logic quiet_l,
                                             input logic quiet_r);
    logic [1:0] pins;
    case (fsel_e'(sel))
      FSEL_OFF:    pins = 2'b00;
      FSEL_CROSS:  pins = {quiet_r, quiet_l};
      default:     pins = {2{quiet_l & quiet_r}};
    endcase
    return pins;
  endfunction

endpackage

// File: rtl/zrf_run_counter.sv
module zrf_run_counter #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                quiet_o
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] run_cnt;
  logic             sample_zero;
  logic             run_full;

  function automatic logic [CNT_W-1:0] next_run(input logic [CNT_W-1:0] cur,
                                                input logic is_zero);
    if (!is_zero)        return '0;
    else if (cur == LIMIT) return LIMIT;
    else                 return cur + 1'b1;
  endfunction

  assign sample_zero = (sample_i == '0);
  assign run_full    = (run_cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)       run_cnt <= '0;
    else if (!en_i)   run_cnt <= '0;
    else if (valid_i) run_cnt <= next_run(run_cnt, sample_zero);
  end

  assign quiet_o = en_i & run_full;

  // R2
  nonzero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && valid_i && !sample_zero) |=> !run_full);
  // R3
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_full && en_i && valid_i && sample_zero) |=> run_full);
  // R4
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !valid_i) |=> $stable(run_cnt));
  // R5
  disabled_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (run_cnt == '0));
  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LIMIT);
endmodule

// File: rtl/zero_run_flagger.sv
module zero_run_flagger #(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [1:0]          flag_sel,
  input  logic [1:0]          chan_en,
  input  logic                mute_en,
  output logic                zflag_l,
  output logic                zflag_r,
  output logic                mute_req_l,
  output logic                mute_req_r
);
  import zrf_pkg::*;

  localparam int NCH = 2;

  logic [SAMPLE_W-1:0] ch_sample [NCH];
  logic [NCH-1:0]      ch_quiet;
  logic [1:0]          pins;

  assign ch_sample[0] = smp_left;
  assign ch_sample[1] = smp_right;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    zrf_run_counter #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (chan_en[ch]),
      .valid_i  (smp_valid),
      .sample_i (ch_sample[ch]),
      .quiet_o  (ch_quiet[ch])
    );
  end

  assign pins       = route_flags(flag_sel, ch_quiet[0], ch_quiet[1]);
  assign zflag_l    = pins[1];
  assign zflag_r    = pins[0];
  assign mute_req_l = mute_en & ch_quiet[0];
  assign mute_req_r = mute_en & ch_quiet[1];

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_sel == 2'b00) |-> (!zflag_l && !zflag_r));
  // R7
  both_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sel[0] |-> (zflag_l == zflag_r));
  // R9
  mute_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_en |-> (!mute_req_l && !mute_req_r));
  // R5
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en[0] && !chan_en[1]) |-> (!mute_req_l && !mute_req_r));
endmodule

// File: tb/zero_run_flagger_bench.sv
module zero_run_flagger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW  = 24;
  localparam int RUN = 1024;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0;
  logic [SW-1:0] smp_left = '0, smp_right = '0;
  logic [1:0] flag_sel = 2'b01, chan_en = 2'b11;
  logic mute_en = 0;
  logic zflag_l, zflag_r, mute_req_l, mute_req_r;

  zero_run_flagger #(.SAMPLE_W(SW), .RUN_LEN(RUN)) u_zero_run_flagger (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .flag_sel(flag_sel), .chan_en(chan_en),
    .mute_en(mute_en), .zflag_l(zflag_l), .zflag_r(zflag_r),
    .mute_req_l(mute_req_l), .mute_req_r(mute_req_r));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [3:0] outs; string tag; } exp_t;
  exp_t sb[$];
  int compared = 0, mismatched = 0;
  int run_l = 0, run_r = 0;
  logic [1:0] c_sel = 2'b01, c_en = 2'b11;
  logic c_mute = 0;
  bit done = 0;

  // Driver: apply one cycle of stimulus, advance the model, queue the expectation.
  task automatic step(input logic v, input logic [SW-1:0] l, input logic [SW-1:0] r,
                      input string tag);
    logic ql, qr, fl, fr;
    @(negedge clk);
    smp_valid = v; smp_left = l; smp_right = r;
    flag_sel = c_sel; chan_en = c_en; mute_en = c_mute;
    @(posedge clk);
    if (!c_en[0]) run_l = 0;
    else if (v) run_l = (l == 0) ? ((run_l < RUN) ? run_l + 1 : run_l) : 0;
    if (!c_en[1]) run_r = 0;
    else if (v) run_r = (r == 0) ? ((run_r < RUN) ? run_r + 1 : run_r) : 0;
    ql = c_en[0] && (run_l >= RUN);
    qr = c_en[1] && (run_r >= RUN);
    if (c_sel == 2'b00)      begin fl = 0; fr = 0; end
    else if (c_sel == 2'b10) begin fl = qr; fr = ql; end
    else                     begin fl = ql && qr; fr = ql && qr; end
    sb.push_back('{outs: {fl, fr, c_mute && ql, c_mute && qr}, tag: tag});
  endtask

  task automatic run(input int n, input logic v, input logic [SW-1:0] l,
                     input logic [SW-1:0] r, input string tag);
    for (int i = 0; i < n; i++) step(v, l, r, tag);
  endtask

  // Monitor: compare outputs a quarter period after each edge.
  initial forever begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (sb.size() > 0) begin
      exp_t e;
      logic [3:0] act;
      e = sb.pop_front();
      act = {zflag_l, zflag_r, mute_req_l, mute_req_r};
      compared++;
      if (act !== e.outs) begin
        mismatched++;
        $display("FAIL %s: {zl,zr,ml,mr} actual=%b expected=%b", e.tag, act, e.outs);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    compared++;  // R10 reset state
    if ({zflag_l, zflag_r, mute_req_l, mute_req_r} !== 4'b0) begin
      mismatched++;
      $display("FAIL R10: actual=%b expected=0000", {zflag_l, zflag_r, mute_req_l, mute_req_r});
    end
    run(RUN - 1, 1, '0, '0, "R1 below threshold");
    run(1, 1, '0, '0, "R1 at threshold");
    run(20, 1, '0, '0, "R3 saturation");
    run(5, 0, 24'hFFFFFF, 24'h000001, "R4 idle nonzero");
    c_sel = 2'b10;
    step(1, '0, 24'h800000, "R2 R8 crossed after clear");
    c_sel = 2'b11;
    step(1, '0, '0, "R7 code 11");
    c_sel = 2'b00;
    step(1, '0, '0, "R6 off");
    c_sel = 2'b10; c_mute = 1;
    step(1, '0, '0, "R9 mute left");
    run(RUN + 6, 1, '0, '0, "R1 right regrow");
    c_sel = 2'b01;
    step(1, '0, '0, "R9 both mute");
    c_en = 2'b10;
    run(3, 1, '0, '0, "R5 left disabled");
    c_en = 2'b11;
    step(1, '0, '0, "R5 left restarted");
    c_mute = 0;
    run(RUN - 2, 1, '0, '0, "R9 mute off");
    run(4, 0, 24'h800000, 24'h800000, "R4 idle at RUN-1");
    step(1, '0, '0, "R4 threshold after idle");
    c_sel = 2'b10; c_mute = 1;
    step(1, 24'h000001, '0, "R2 left lsb clear");
    c_en = 2'b00;
    step(1, '0, '0, "R5 both disabled");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule